// File: doc/BRIEF.md
# SCSI Initiator Byte Handshake Sequencer

This block is the initiator-side engine for the information transfer phase of a SCSI bus. It moves one byte for each REQ/ACK handshake, up to a byte count that is loaded when a transfer starts. For every byte it waits for the target's REQ and samples the I/O line to decide the direction. An inbound byte is copied from the bus into a small FIFO. An outbound byte is taken from the head of the same FIFO and driven onto the bus. The block then raises ACK, holds it until the target drops REQ, releases ACK and decrements the count.

The host side fills the FIFO before an outbound transfer and drains it after an inbound one, or does so while the transfer runs. A transfer ends when the count reaches zero. It also ends when an outbound byte is requested, the FIFO holds nothing and the transfer-enable input is set. In that case a sticky transfer-out error is raised and the byte is never acknowledged. When transfer-enable is clear, the same situation makes the block wait for the host instead. Arbitration, selection and bus phase decoding belong to other blocks.

Top module: `scsi_byte_seq`

## Requirements
- R1: After reset `scsiAck`, `scsiDataOe`, `ctrlBusy`, `xferInProgress` and `xferOutErr` are 0, `fifoEmpty` is 1 and `countLeft` is 0.
- R2: A `start` pulse in a cycle where the sequencer is idle and `countLoad` is nonzero loads `countLeft` and sets both `ctrlBusy` and `xferInProgress` on the following cycle. A `start` with a zero count, or a `start` while a transfer runs, changes nothing.
- R3: When REQ is seen with I/O at 1, the byte on `scsiDataIn` is written into the FIFO. When REQ is seen with I/O at 0, the FIFO head is removed and driven on `scsiDataOut` with `scsiDataOe` at 1 while ACK is high.
- R4: ACK rises only after the byte has been handled. It stays high as long as REQ stays high and falls only after REQ has been seen low.
- R5: Each completed handshake lowers `countLeft` by one. When it reaches zero the sequencer goes idle with `ctrlBusy`, `xferInProgress`, ACK and `scsiDataOe` at 0.
- R6: An outbound byte requested while the FIFO is empty and `xferEnable` is 1 sets `xferOutErr` without raising ACK. The transfer is abandoned: `ctrlBusy` and `xferInProgress` return to 0 and `countLeft` keeps its value. The error clears on the next accepted `start`.
- R7: An outbound byte requested while the FIFO is empty and `xferEnable` is 0 stalls with ACK low and `ctrlBusy` high. The handshake completes once the host pushes a byte.
- R8: An inbound byte arriving while the FIFO is full stalls with ACK low. It is captured once the host pops an entry.
- R9: The FIFO returns bytes in arrival order. A host push into a full FIFO and a host pop from an empty FIFO are ignored. `hostPopData` shows the current head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer of `countLoad` bytes |
| countLoad | input | CNT_W | Byte count taken on an accepted start |
| xferEnable | input | 1 | Turns an empty FIFO on an outbound byte into an error instead of a wait |
| scsiReq | input | 1 | Target REQ, active high |
| scsiIo | input | 1 | Target I/O, 1 = inbound to initiator |
| scsiDataIn | input | DATA_W | Bus data from the target |
| scsiAck | output | 1 | Initiator ACK, active high |
| scsiDataOut | output | DATA_W | Bus data toward the target |
| scsiDataOe | output | 1 | Enable for `scsiDataOut` |
| hostPush | input | 1 | Host write into the FIFO |
| hostPushData | input | DATA_W | Host write data |
| hostPop | input | 1 | Host removes the FIFO head |
| hostPopData | output | DATA_W | Current FIFO head |
| fifoEmpty | output | 1 | FIFO holds nothing |
| fifoFull | output | 1 | FIFO holds FIFO_DEPTH bytes |
| countLeft | output | CNT_W | Bytes still to transfer |
| ctrlBusy | output | 1 | Controller busy status |
| xferInProgress | output | 1 | Transfer in progress status |
| xferOutErr | output | 1 | Sticky transfer-out error |

## Verification
The hardest states to reach are the two stalls and the abort. Each needs the target to hold REQ while the FIFO sits at a boundary. For an outbound stall the FIFO must be empty, and `xferEnable` picks a wait or an error. For an inbound stall the FIFO must already be full. Directed sequences first fill the FIFO with an inbound transfer longer than its depth, or start an outbound transfer with nothing queued. They then hold REQ for several cycles and check that ACK stays low before the host pop or push releases the handshake. Random transfers of random length, direction and timing follow, checked against a queue model of the FIFO.

// File: rtl/scsi_byte_seq_pkg.sv
package scsi_byte_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_REQ,
    ST_SEND,
    ST_RECV,
    ST_ACK_ON,
    ST_WAIT_REQ_LOW,
    ST_ACK_OFF
  } seqState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCount;
    logic decCount;
    logic busPush;
    logic busPop;
    logic driveOut;
  } seqStrobe_t;

endpackage

// File: rtl/scsi_byte_seq_fifo.sv
module scsi_byte_seq_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pushEn,
  input  logic [W-1:0] pushData,
  input  logic         popEn,
  output logic [W-1:0] headData,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] level;
  logic             doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty  = (level == '0);
  assign full   = (level == LVL_W'(DEPTH));
  assign doPush = pushEn && !full;
  assign doPop  = popEn && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_FIFO_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    full && pushEn && !popEn |=> full) else $error("full fifo lost state"); // R9
  AST_FIFO_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    empty && popEn && !pushEn |=> empty) else $error("empty fifo popped"); // R9

endmodule

// File: rtl/scsi_byte_seq_dp.sv
module scsi_byte_seq_dp
  import scsi_byte_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [CNT_W-1:0]  countLoad,
  input  logic [DATA_W-1:0] scsiDataIn,
  input  logic              hostPush,
  input  logic [DATA_W-1:0] hostPushData,
  input  logic              hostPop,
  output logic [DATA_W-1:0] hostPopData,
  output logic [DATA_W-1:0] scsiDataOut,
  output logic              scsiDataOe,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [CNT_W-1:0]  countLeft,
  output logic              countIsOne
);
  logic [DATA_W-1:0] outReg;
  logic [CNT_W-1:0]  countQ;
  logic              fPush, fPop;
  logic [DATA_W-1:0] fPushData;
  logic [DATA_W-1:0] headData;

  // Bus side has priority on the single FIFO port of each kind
  assign fPush     = strb.busPush || hostPush;
  assign fPushData = strb.busPush ? scsiDataIn : hostPushData;
  assign fPop      = strb.busPop || hostPop;

  scsi_byte_seq_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (fPush),
    .pushData (fPushData),
    .popEn    (fPop),
    .headData (headData),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReg <= '0;
      countQ <= '0;
    end else begin
      if (strb.busPop) outReg <= headData;
      if (strb.loadCount)     countQ <= countLoad;
      else if (strb.decCount) countQ <= countQ - 1'b1;
    end
  end

  assign hostPopData = headData;
  assign scsiDataOut = outReg;
  assign scsiDataOe  = strb.driveOut;
  assign countLeft   = countQ;
  assign countIsOne  = (countQ == CNT_W'(1));

  AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rstN)
    strb.decCount |=> countQ == $past(countQ) - 1'b1) else $error("count step"); // R5
  AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.driveOut && $past(strb.driveOut) |-> $stable(outReg)) else $error("out data moved"); // R3

endmodule

// File: rtl/scsi_byte_seq_ctrl.sv
module scsi_byte_seq_ctrl
  import scsi_byte_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [CNT_W-1:0] countLoad,
  input  logic             xferEnable,
  input  logic             scsiReq,
  input  logic             scsiIo,
  input  logic             fifoEmpty,
  input  logic             fifoFull,
  input  logic             countIsOne,
  output seqStrobe_t       strb,
  output logic             scsiAck,
  output logic             ctrlBusy,
  output logic             xferInProgress,
  output logic             xferOutErr
);
  seqState_t stateQ, stateD;
  logic      busyQ, xipQ, errQ, dirInQ;
  logic      startOk, errSet;

  assign startOk = (stateQ == ST_IDLE) && start && (countLoad != '0);

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    errSet = 1'b0;
    case (stateQ)
      ST_IDLE: begin
        if (startOk) begin
          strb.loadCount = 1'b1;
          stateD = ST_WAIT_REQ;
        end
      end
      ST_WAIT_REQ: begin
        if (scsiReq) stateD = scsiIo ? ST_RECV : ST_SEND;
      end
      ST_RECV: begin
        if (!fifoFull) begin
          strb.busPush = 1'b1;
          stateD = ST_ACK_ON;
        end
      end
      ST_SEND: begin
        if (!fifoEmpty) begin
          strb.busPop = 1'b1;
          stateD = ST_ACK_ON;
        end else if (xferEnable) begin
          errSet = 1'b1;
          stateD = ST_IDLE;
        end
      end
      ST_ACK_ON: stateD = ST_WAIT_REQ_LOW;
      ST_WAIT_REQ_LOW: begin
        if (!scsiReq) stateD = ST_ACK_OFF;
      end
      ST_ACK_OFF: begin
        strb.decCount = 1'b1;
        stateD = countIsOne ? ST_IDLE : ST_WAIT_REQ;
      end
      default: stateD = ST_IDLE;
    endcase
    strb.driveOut = !dirInQ &&
      (stateQ == ST_ACK_ON || stateQ == ST_WAIT_REQ_LOW || stateQ == ST_ACK_OFF);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      busyQ  <= 1'b0;
      xipQ   <= 1'b0;
      errQ   <= 1'b0;
      dirInQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_WAIT_REQ && scsiReq) dirInQ <= scsiIo;
      if (startOk) begin
        busyQ <= 1'b1;
        xipQ  <= 1'b1;
        errQ  <= 1'b0;
      end else if (stateQ != ST_IDLE && stateD == ST_IDLE) begin
        busyQ <= 1'b0;
        xipQ  <= 1'b0;
      end
      if (errSet) errQ <= 1'b1;
    end
  end

  assign scsiAck        = (stateQ == ST_ACK_ON) || (stateQ == ST_WAIT_REQ_LOW);
  assign ctrlBusy       = busyQ;
  assign xferInProgress = xipQ;
  assign xferOutErr     = errQ;

  AST_START_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> ctrlBusy && xferInProgress) else $error("start status"); // R2
  AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    scsiAck && scsiReq |=> scsiAck) else $error("ack dropped early"); // R4
  AST_ACK_FALL_REQ_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(scsiAck) |-> !$past(scsiReq)) else $error("ack fell with req high"); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlBusy |-> !scsiAck && !strb.driveOut) else $error("bus active idle"); // R5
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(xferOutErr) |-> !ctrlBusy && !xferInProgress && !scsiAck) else $error("err abort"); // R6
  AST_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_SEND && fifoEmpty && !xferEnable |=> !scsiAck) else $error("ack on empty"); // R7
  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rstN)
    stateQ == ST_RECV && fifoFull |=> !scsiAck) else $error("ack on full"); // R8

endmodule

// File: rtl/scsi_byte_seq.sv
module scsi_byte_seq
  import scsi_byte_seq_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int CNT_W      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CNT_W-1:0]  countLoad,
  input  logic              xferEnable,
  input  logic              scsiReq,
  input  logic              scsiIo,
  input  logic [DATA_W-1:0] scsiDataIn,
  output logic              scsiAck,
  output logic [DATA_W-1:0] scsiDataOut,
  output logic              scsiDataOe,
  input  logic              hostPush,
  input  logic [DATA_W-1:0] hostPushData,
  input  logic              hostPop,
  output logic [DATA_W-1:0] hostPopData,
  output logic              fifoEmpty,
  output logic              fifoFull,
  output logic [CNT_W-1:0]  countLeft,
  output logic              ctrlBusy,
  output logic              xferInProgress,
  output logic              xferOutErr
);
  seqStrobe_t strb;
  logic       countIsOne;

  scsi_byte_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .start          (start),
    .countLoad      (countLoad),
    .xferEnable     (xferEnable),
    .scsiReq        (scsiReq),
    .scsiIo         (scsiIo),
    .fifoEmpty      (fifoEmpty),
    .fifoFull       (fifoFull),
    .countIsOne     (countIsOne),
    .strb           (strb),
    .scsiAck        (scsiAck),
    .ctrlBusy       (ctrlBusy),
    .xferInProgress (xferInProgress),
    .xferOutErr     (xferOutErr)
  );

  scsi_byte_seq_dp #(.DATA_W(DATA_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .countLoad    (countLoad),
    .scsiDataIn   (scsiDataIn),
    .hostPush     (hostPush),
    .hostPushData (hostPushData),
    .hostPop      (hostPop),
    .hostPopData  (hostPopData),
    .scsiDataOut  (scsiDataOut),
    .scsiDataOe   (scsiDataOe),
    .fifoEmpty    (fifoEmpty),
    .fifoFull     (fifoFull),
    .countLeft    (countLeft),
    .countIsOne   (countIsOne)
  );

endmodule

// File: tb/scsi_byte_seq_bench.sv
`timescale 1ns/1ps
module scsi_byte_seq_bench;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [CNT_W-1:0] countLoad = '0;
  logic xferEnable = 1'b0;
  logic scsiReq = 1'b0;
  logic scsiIo = 1'b0;
  logic [DATA_W-1:0] scsiDataIn = '0;
  logic scsiAck;
  logic [DATA_W-1:0] scsiDataOut;
  logic scsiDataOe;
  logic hostPush = 1'b0;
  logic [DATA_W-1:0] hostPushData = '0;
  logic hostPop = 1'b0;
  logic [DATA_W-1:0] hostPopData;
  logic fifoEmpty, fifoFull;
  logic [CNT_W-1:0] countLeft;
  logic ctrlBusy, xferInProgress, xferOutErr;

  int checks = 0;
  int errors = 0;
  logic [DATA_W-1:0] model[$];

  always #2.5 clk = ~clk;

  scsi_byte_seq #(.DATA_W(DATA_W), .FIFO_DEPTH(DEPTH), .CNT_W(CNT_W)) u_scsi_byte_seq (
    .clk(clk), .rstN(rstN), .start(start), .countLoad(countLoad),
    .xferEnable(xferEnable), .scsiReq(scsiReq), .scsiIo(scsiIo),
    .scsiDataIn(scsiDataIn), .scsiAck(scsiAck), .scsiDataOut(scsiDataOut),
    .scsiDataOe(scsiDataOe), .hostPush(hostPush), .hostPushData(hostPushData),
    .hostPop(hostPop), .hostPopData(hostPopData), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .countLeft(countLeft), .ctrlBusy(ctrlBusy),
    .xferInProgress(xferInProgress), .xferOutErr(xferOutErr)
  );

  function automatic int expLevelAfterPush(input int lvl);
    return (lvl < DEPTH) ? lvl + 1 : lvl;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic waitAck(input logic level, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (scsiAck == level) begin ok = 1'b1; break; end
    end
  endtask

  task automatic pushHost(input logic [DATA_W-1:0] d);
    @(negedge clk);
    hostPush = 1'b1; hostPushData = d;
    if (model.size() < DEPTH) model.push_back(d);
    @(negedge clk);
    hostPush = 1'b0;
  endtask

  task automatic popHost(input string tag);
    logic [DATA_W-1:0] exp;
    @(negedge clk);
    exp = model.pop_front();
    chk(hostPopData == exp, tag, hostPopData, exp);
    hostPop = 1'b1;
    @(negedge clk);
    hostPop = 1'b0;
  endtask

  task automatic startXfer(input int n);
    @(negedge clk);
    start = 1'b1; countLoad = CNT_W'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  // One target handshake; expOut checked for outbound bytes
  task automatic target(input logic io, input logic [DATA_W-1:0] din,
                        input logic [DATA_W-1:0] expOut);
    bit ok;
    @(negedge clk);
    scsiReq = 1'b1; scsiIo = io; scsiDataIn = din;
    waitAck(1'b1, ok);
    chk(ok, "R4 ack rise", scsiAck, 1);
    if (!io) chk(scsiDataOe && scsiDataOut == expOut, "R3 out data", scsiDataOut, expOut);
    repeat ($urandom % 3) begin
      @(negedge clk);
      chk(scsiAck, "R4 ack held with req", scsiAck, 1);
    end
    scsiReq = 1'b0;
    waitAck(1'b0, ok);
    chk(ok, "R4 ack fall", scsiAck, 0);
    if (io) model.push_back(din);
  endtask

  task automatic endCheck();
    repeat (2) @(negedge clk);
    chk(!ctrlBusy && !xferInProgress && countLeft == 0 && !scsiDataOe,
        "R5 end idle", {ctrlBusy, xferInProgress, countLeft}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit ok;
    logic [DATA_W-1:0] b;
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scsiAck && !scsiDataOe && !ctrlBusy && !xferInProgress && !xferOutErr &&
        fifoEmpty && countLeft == 0, "R1 reset",
        {scsiAck, scsiDataOe, ctrlBusy, xferInProgress, xferOutErr, fifoEmpty}, 1);

    // R9 overflow ignored, order kept
    for (int i = 0; i < DEPTH + 1; i++) pushHost(DATA_W'(8'h10 + i));
    chk(fifoFull, "R9 full", fifoFull, 1);
    for (int i = 0; i < DEPTH; i++) popHost("R9 order");
    @(negedge clk);
    chk(fifoEmpty, "R9 extra push dropped", fifoEmpty, 1);
    @(negedge clk); hostPop = 1'b1; @(negedge clk); hostPop = 1'b0;
    pushHost(8'h5A);
    popHost("R9 pop on empty ignored");
    @(negedge clk);
    chk(fifoEmpty, "R9 empty after", fifoEmpty, 1);

    // R2 zero count ignored
    startXfer(0);
    @(negedge clk);
    chk(!ctrlBusy && !xferInProgress, "R2 zero start ignored", ctrlBusy, 0);

    // R7 empty stall with enable low
    xferEnable = 1'b0;
    startXfer(1);
    chk(ctrlBusy && xferInProgress && countLeft == 1, "R2 start status", countLeft, 1);
    scsiReq = 1'b1; scsiIo = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (scsiAck) ok = 1'b0; end
    chk(ok && ctrlBusy, "R7 stall ack low", scsiAck, 0);
    pushHost(8'hC3);
    waitAck(1'b1, ok);
    chk(ok && scsiDataOe && scsiDataOut == 8'hC3, "R7 resume data", scsiDataOut, 8'hC3);
    void'(model.pop_front());
    scsiReq = 1'b0;
    waitAck(1'b0, ok);
    endCheck();

    // R6 empty with enable high -> error abort
    xferEnable = 1'b1;
    startXfer(3);
    scsiReq = 1'b1; scsiIo = 1'b0;
    ok = 1'b1;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (scsiAck) ok = 1'b0; end
    chk(ok && xferOutErr, "R6 error set, no ack", xferOutErr, 1);
    chk(!ctrlBusy && !xferInProgress && countLeft == 3, "R6 abort keeps count", countLeft, 3);
    scsiReq = 1'b0;
    startXfer(1);
    chk(!xferOutErr, "R6 error cleared by start", xferOutErr, 0);
    target(1'b1, 8'h77, 8'h00);
    endCheck();
    popHost("R3 inbound byte");

    // R8 inbound full stall, R2 start during transfer ignored
    startXfer(DEPTH + 1);
    for (int i = 0; i < DEPTH; i++) target(1'b1, DATA_W'(8'hA0 + i), 8'h00);
    startXfer(9);
    chk(countLeft == 1, "R2 start while busy ignored", countLeft, 1);
    @(negedge clk);
    scsiReq = 1'b1; scsiIo = 1'b1; scsiDataIn = 8'hEE;
    ok = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (scsiAck) ok = 1'b0; end
    chk(ok && fifoFull, "R8 full stall", scsiAck, 0);
    popHost("R8 first byte");
    waitAck(1'b1, ok);
    chk(ok, "R8 resumed", scsiAck, 1);
    scsiReq = 1'b0;
    model.push_back(8'hEE);
    waitAck(1'b0, ok);
    endCheck();
    for (int i = 0; i < DEPTH; i++) popHost("R8 drain order");

    // Random transfers
    for (int t = 0; t < 30; t++) begin
      int len;
      len = 1 + ($urandom % DEPTH);
      xferEnable = $urandom % 2;
      if ($urandom % 2) begin
        for (int i = 0; i < len; i++) pushHost(DATA_W'($urandom));
        startXfer(len);
        for (int i = 0; i < len; i++) begin
          b = model.pop_front();
          target(1'b0, DATA_W'($urandom), b);
          repeat ($urandom % 3) @(negedge clk);
        end
        endCheck();
      end else begin
        startXfer(len);
        for (int i = 0; i < len; i++) begin
          target(1'b1, DATA_W'($urandom), 8'h00);
          repeat ($urandom % 3) @(negedge clk);
        end
        endCheck();
        chk(model.size() == expLevelAfterPush(len - 1) || model.size() == len,
            "R3 inbound count", model.size(), len);
        for (int i = 0; i < len; i++) popHost("R3 inbound data");
      end
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule